// File: doc/BRIEF.md
# Digital Optical-Black Clamp Loop

This block takes a stream of unsigned 14-bit image-sensor pixel codes and removes the sensor's dark offset from every code. A window strobe marks the shielded optical-black pixels at the start of each line. During that window the block updates a fractional offset estimate, one step per pixel, so that the measured black level settles on a programmable target. Every pixel, inside or outside the window, leaves the block with the integer part of the current estimate subtracted. The result is saturated to the 14-bit code range.

A shielded pixel can be defective and read near full scale. Such a pixel would pull the estimate upward, so any window sample above a programmable reject level is discarded. The last sample that passed the test takes its place in that update. A second strobe blanks the output. While it is high, the output code is forced to zero and the output beat is dropped. The target, reject level and loop gain come in as plain register inputs. A new value is taken at the rising edge of the window strobe and held until the next rising edge.

Pixels enter and leave through a valid/ready stream with a single output register. The upstream source may present a pixel only while holding its code steady until `pix_in_ready` is high. The output side may stall by holding `pix_out_ready` low. In that case the output beat is frozen and the input is stalled in the same cycle. The window and blanking strobes are sideband signals that belong to the beat presented in the same cycle.

Top module: `ob_clamp_loop`

## Requirements
- R1: The offset estimate changes only in a cycle in which a pixel is accepted (`pix_in_valid` and `pix_in_ready` both high) while `clamp_win` is high. In every other cycle it keeps its value.
- R2: Each window update adds `(s*2^F - tgt*2^F - off) >>> (g+1)` to the signed offset `off`. Here F = 8 fractional bits, `s` is the accepted black sample, `tgt` is the target, `g` is the 3-bit gain code (shift 1 to 8), and `>>>` is an arithmetic (flooring) shift.
- R3: With gain code 0 and a constant black level, 20 window pixels bring the corrected black pixel to within 1 LSB of the target.
- R4: A window sample strictly greater than the reject level is a hot pixel. It is replaced in the update by the last non-hot window sample, and it does not replace that stored sample.
- R5: After reset the offset is zero and the stored last-accepted sample equals the target. A hot first window pixel therefore leaves the offset unchanged.
- R6: A beat accepted while `out_blank` is high produces `pix_out_data` = 0 with `pix_out_valid` low.
- R7: The output code is `in - floor(off/2^F)`, saturated to the range 0 to 16383.
- R8: The target, reject level and gain in use are loaded from the register inputs during reset. They are reloaded in the cycle where `clamp_win` rises, and that cycle's update already uses the new values. At all other times they stay fixed.
- R9: An accepted, unblanked pixel appears on the output exactly one clock later with `pix_out_valid` high. After reset `pix_out_valid` is low and `pix_in_ready` is high.
- R10: While `pix_out_valid` is high and `pix_out_ready` is low, the output beat stays unchanged and `pix_in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_in_valid | input | 1 | Input pixel present |
| pix_in_ready | output | 1 | Block accepts the input pixel this cycle |
| pix_in_data | input | 14 | Raw pixel code |
| clamp_win | input | 1 | Marks the beat as an optical-black pixel |
| out_blank | input | 1 | Masks the output of the beat |
| cfg_target | input | 14 | Target black level |
| cfg_reject | input | 14 | Hot-pixel reject level |
| cfg_gain | input | 3 | Loop gain code, shift = code + 1 |
| pix_out_valid | output | 1 | Corrected pixel present |
| pix_out_ready | input | 1 | Downstream accepts the output |
| pix_out_data | output | 14 | Corrected pixel code |

## Verification
On every cycle, the embedded properties check four rules:
- the offset holds outside accepted window beats;
- a hot pixel leaves the stored black sample alone;
- the active settings move only at a window start;
- blanking, latency and output stall behave as specified.

The arithmetic itself can only be shown by the directed scenarios, which run a bench model of the update. This covers the exact step sizes, settling within 20 pixels, substitution of the target for a hot first pixel, mid-window setting changes, and saturation at both ends of the code range.

// File: rtl/ob_clamp_pkg.sv
package ob_clamp_pkg;
  localparam int GAIN_W = 3;

  typedef logic [GAIN_W-1:0] gain_code_t;

  // Gain code c selects a right shift of c+1 positions.
  function automatic logic [GAIN_W:0] gain_to_shift(input gain_code_t code);
    return {1'b0, code} + 1'b1;
  endfunction
endpackage

// File: rtl/ob_cfg_shadow.sv
module ob_cfg_shadow #(
  parameter int PIX_W = 14
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clamp,
  input  logic [PIX_W-1:0]                tgt_in,
  input  logic [PIX_W-1:0]                thr_in,
  input  ob_clamp_pkg::gain_code_t        gain_in,
  output logic [PIX_W-1:0]                tgt_eff,
  output logic [PIX_W-1:0]                thr_eff,
  output ob_clamp_pkg::gain_code_t        gain_eff,
  output logic                            win_start
);
  logic                     clamp_q;
  logic [PIX_W-1:0]         tgt_q;
  logic [PIX_W-1:0]         thr_q;
  ob_clamp_pkg::gain_code_t gain_q;

  assign win_start = clamp && !clamp_q;

  // The edge cycle already sees the new values.
  assign tgt_eff  = win_start ? tgt_in  : tgt_q;
  assign thr_eff  = win_start ? thr_in  : thr_q;
  assign gain_eff = win_start ? gain_in : gain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clamp_q <= 1'b0;
      tgt_q   <= tgt_in;
      thr_q   <= thr_in;
      gain_q  <= gain_in;
    end else begin
      clamp_q <= clamp;
      if (win_start) begin
        tgt_q  <= tgt_in;
        thr_q  <= thr_in;
        gain_q <= gain_in;
      end
    end
  end

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_start |=> ($stable(tgt_q) && $stable(thr_q) && $stable(gain_q)));
endmodule

// File: rtl/ob_hot_reject.sv
module ob_hot_reject #(
  parameter int PIX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [PIX_W-1:0] sample,
  input  logic [PIX_W-1:0] thr,
  input  logic [PIX_W-1:0] rst_val,
  output logic [PIX_W-1:0] acc_sample,
  output logic             hot
);
  logic [PIX_W-1:0] last_good_q;

  assign hot        = sample > thr;
  assign acc_sample = hot ? last_good_q : sample;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_good_q <= rst_val;
    end else if (upd && !hot) begin
      last_good_q <= sample;
    end
  end

  assert_hot_keeps_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && hot) |=> $stable(last_good_q));
  assert_good_is_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !hot) |=> (last_good_q == $past(sample)));
endmodule

// File: rtl/ob_offset_acc.sv
module ob_offset_acc #(
  parameter int PIX_W  = 14,
  parameter int FRAC_W = 8,
  parameter int ACC_W  = PIX_W + FRAC_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic [PIX_W-1:0]         acc_sample,
  input  logic [PIX_W-1:0]         tgt,
  input  ob_clamp_pkg::gain_code_t gain,
  output logic signed [ACC_W-1:0]  offset
);
  localparam int ERR_W = ACC_W + 1;
  localparam int PAD_W = ERR_W - PIX_W - FRAC_W;

  logic signed [ERR_W-1:0] samp_fx;
  logic signed [ERR_W-1:0] tgt_fx;
  logic signed [ERR_W-1:0] off_ext;
  logic signed [ERR_W-1:0] err;
  logic signed [ERR_W-1:0] step;
  logic signed [ACC_W-1:0] off_q;
  logic [ob_clamp_pkg::GAIN_W:0] shamt;

  assign samp_fx = $signed({{PAD_W{1'b0}}, acc_sample, {FRAC_W{1'b0}}});
  assign tgt_fx  = $signed({{PAD_W{1'b0}}, tgt, {FRAC_W{1'b0}}});
  assign off_ext = {off_q[ACC_W-1], off_q};
  assign err     = samp_fx - tgt_fx - off_ext;
  assign shamt   = ob_clamp_pkg::gain_to_shift(gain);
  assign step    = err >>> shamt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (upd) begin
      off_q <= off_q + step[ACC_W-1:0];
    end
  end

  assign offset = off_q;

  assert_offset_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(offset));
endmodule

// File: rtl/ob_out_stage.sv
module ob_out_stage #(
  parameter int                 PIX_W  = 14,
  parameter int                 FRAC_W = 8,
  parameter int                 ACC_W  = PIX_W + FRAC_W + 2,
  parameter logic [PIX_W-1:0]   MASK   = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PIX_W-1:0]        in_data,
  input  logic                    blank,
  input  logic signed [ACC_W-1:0] offset,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [PIX_W-1:0]        out_data
);
  localparam int INT_W = ACC_W - FRAC_W;
  localparam int DIF_W = INT_W + 2;
  localparam logic signed [DIF_W-1:0] TOP = DIF_W'((1 << PIX_W) - 1);

  logic signed [INT_W-1:0] off_int;
  logic signed [DIF_W-1:0] pix_s;
  logic signed [DIF_W-1:0] diff;
  logic [PIX_W-1:0]        corr;
  logic                    vld_q;
  logic [PIX_W-1:0]        dat_q;

  assign off_int = offset[ACC_W-1:FRAC_W];
  assign pix_s   = $signed({{(DIF_W-PIX_W){1'b0}}, in_data});
  assign diff    = pix_s - {{2{off_int[INT_W-1]}}, off_int};

  always_comb begin
    if (diff < 0)        corr = '0;
    else if (diff > TOP) corr = '1;
    else                 corr = diff[PIX_W-1:0];
  end

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= MASK;
    end else if (in_ready) begin
      vld_q <= in_valid && !blank;
      dat_q <= blank ? MASK : corr;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  assert_blank_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && blank) |=> (!out_valid && out_data == MASK));
  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !blank) |=> out_valid);
  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/ob_clamp_loop.sv
module ob_clamp_loop #(
  parameter int PIX_W  = 14,
  parameter int FRAC_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pix_in_valid,
  output logic                            pix_in_ready,
  input  logic [PIX_W-1:0]                pix_in_data,
  input  logic                            clamp_win,
  input  logic                            out_blank,
  input  logic [PIX_W-1:0]                cfg_target,
  input  logic [PIX_W-1:0]                cfg_reject,
  input  logic [ob_clamp_pkg::GAIN_W-1:0] cfg_gain,
  output logic                            pix_out_valid,
  input  logic                            pix_out_ready,
  output logic [PIX_W-1:0]                pix_out_data
);
  localparam int ACC_W = PIX_W + FRAC_W + 2;

  logic [PIX_W-1:0]         tgt_eff;
  logic [PIX_W-1:0]         thr_eff;
  ob_clamp_pkg::gain_code_t gain_eff;
  logic                     win_start;
  logic                     upd;
  logic [PIX_W-1:0]         acc_sample;
  logic                     hot;
  logic signed [ACC_W-1:0]  offset;

  assign upd = pix_in_valid && pix_in_ready && clamp_win;

  ob_cfg_shadow #(.PIX_W(PIX_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .clamp(clamp_win),
    .tgt_in(cfg_target), .thr_in(cfg_reject), .gain_in(cfg_gain),
    .tgt_eff(tgt_eff), .thr_eff(thr_eff), .gain_eff(gain_eff),
    .win_start(win_start)
  );

  ob_hot_reject #(.PIX_W(PIX_W)) rej_i (
    .clk(clk), .rst_n(rst_n), .upd(upd), .sample(pix_in_data),
    .thr(thr_eff), .rst_val(cfg_target),
    .acc_sample(acc_sample), .hot(hot)
  );

  ob_offset_acc #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .upd(upd), .acc_sample(acc_sample),
    .tgt(tgt_eff), .gain(gain_eff), .offset(offset)
  );

  ob_out_stage #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .MASK('0)) out_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pix_in_valid), .in_ready(pix_in_ready), .in_data(pix_in_data),
    .blank(out_blank), .offset(offset),
    .out_valid(pix_out_valid), .out_ready(pix_out_ready), .out_data(pix_out_data)
  );

  // A hot first window pixel after reset substitutes the reset-time target.
  assert_first_hot_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && hot && offset == 0 && acc_sample == tgt_eff) |=> (offset == 0));
endmodule

// File: tb/ob_clamp_loop_tb_top.sv
`timescale 1ns/1ps
module ob_clamp_loop_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_in_valid = 1'b0;
  logic        pix_in_ready;
  logic [13:0] pix_in_data = '0;
  logic        clamp_win = 1'b0;
  logic        out_blank = 1'b0;
  logic [13:0] cfg_target = 14'd64;
  logic [13:0] cfg_reject = 14'd4000;
  logic [2:0]  cfg_gain = 3'd0;
  logic        pix_out_valid;
  logic        pix_out_ready = 1'b1;
  logic [13:0] pix_out_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  longint m_off;
  longint m_last;
  longint m_tgt, m_thr, m_gain;
  bit     m_clamp_prev;

  always #2.5 clk = ~clk;

  ob_clamp_loop dut_i (
    .clk(clk), .rst_n(rst_n),
    .pix_in_valid(pix_in_valid), .pix_in_ready(pix_in_ready), .pix_in_data(pix_in_data),
    .clamp_win(clamp_win), .out_blank(out_blank),
    .cfg_target(cfg_target), .cfg_reject(cfg_reject), .cfg_gain(cfg_gain),
    .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready), .pix_out_data(pix_out_data)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat14(input longint v);
    if (v < 0) return 0;
    if (v > 16383) return 16383;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pix_in_valid = 1'b0; clamp_win = 1'b0; out_blank = 1'b0;
    pix_out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_off = 0; m_last = cfg_target; m_tgt = cfg_target; m_thr = cfg_reject;
    m_gain = cfg_gain; m_clamp_prev = 1'b0;
  endtask

  // One clock with no pixel; the strobe is still sampled for its edge.
  task automatic idle(input bit clp);
    @(negedge clk);
    pix_in_valid = 1'b0; clamp_win = clp; out_blank = 1'b0;
    if (clp && !m_clamp_prev) begin
      m_tgt = cfg_target; m_thr = cfg_reject; m_gain = cfg_gain;
    end
    m_clamp_prev = clp;
    @(posedge clk);
  endtask

  // One accepted pixel; checks the output one clock later against the model.
  task automatic step(input longint pix, input bit clp, input bit blk, input string tag);
    longint exp_d, acc;
    bit exp_v;
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_data = 14'(pix); clamp_win = clp; out_blank = blk;
    if (clp && !m_clamp_prev) begin
      m_tgt = cfg_target; m_thr = cfg_reject; m_gain = cfg_gain;
    end
    m_clamp_prev = clp;
    exp_v = !blk;
    exp_d = blk ? 0 : sat14(pix - (m_off >>> 8));
    @(posedge clk);
    #1;
    check(pix_out_valid == exp_v, tag, pix_out_valid, exp_v);
    check(pix_out_data == 14'(exp_d), tag, pix_out_data, exp_d);
    if (clp) begin
      if (pix > m_thr) acc = m_last;
      else begin acc = pix; m_last = pix; end
      m_off = m_off + ((acc * 256 - m_tgt * 256 - m_off) >>> (m_gain + 1));
    end
    pix_in_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    cfg_target = 14'd64; cfg_reject = 14'd4000; cfg_gain = 3'd0;
    do_reset();
    #1;
    check(pix_out_valid == 1'b0, "R9", pix_out_valid, 0);
    check(pix_in_ready == 1'b1, "R9", pix_in_ready, 1);
  endtask

  task automatic t_passthrough();
    // R7, R9: zero offset passes codes through unchanged
    step(0, 0, 0, "R7");
    step(12345, 0, 0, "R7");
    step(16383, 0, 0, "R9");
  endtask

  task automatic t_first_hot();
    cfg_target = 14'd100; cfg_reject = 14'd2000; cfg_gain = 3'd1;
    do_reset();
    step(9000, 1, 0, "R5");
    step(100, 1, 0, "R5");
    idle(0);
    step(500, 0, 0, "R5");
    check(pix_out_data == 14'd500, "R5", pix_out_data, 500);
  endtask

  task automatic t_converge();
    cfg_target = 14'd64; cfg_reject = 14'd4000; cfg_gain = 3'd0;
    do_reset();
    for (int i = 0; i < 20; i++) step(300, 1, 0, "R2");
    idle(0);
    step(300, 0, 0, "R3");
    check((pix_out_data >= 14'd63) && (pix_out_data <= 14'd65), "R3", pix_out_data, 64);
    // R1: strobe high without a pixel, and idle cycles, leave the offset alone
    idle(0); idle(1); idle(1); idle(0);
    step(300, 0, 0, "R1");
    step(1000, 0, 0, "R1");
  endtask

  task automatic t_hot_line();
    cfg_target = 14'd50; cfg_reject = 14'd1000; cfg_gain = 3'd2;
    do_reset();
    step(200, 1, 0, "R4");
    step(16000, 1, 0, "R4");
    step(1000, 1, 0, "R4");
    step(1001, 1, 0, "R4");
    step(220, 1, 0, "R4");
    step(15000, 1, 0, "R4");
    idle(0);
    step(800, 0, 0, "R4");
  endtask

  task automatic t_blank();
    step(777, 0, 1, "R6");
    step(777, 1, 1, "R6");
    step(777, 0, 0, "R6");
  endtask

  task automatic t_cfg_latch();
    cfg_target = 14'd64; cfg_reject = 14'd4000; cfg_gain = 3'd3;
    do_reset();
    step(400, 1, 0, "R8");
    cfg_target = 14'd900; cfg_gain = 3'd0; cfg_reject = 14'd10;
    step(400, 1, 0, "R8");
    step(400, 1, 0, "R8");
    idle(0);
    step(400, 0, 0, "R8");
    step(400, 1, 0, "R8");
    step(400, 1, 0, "R8");
    idle(0);
    step(400, 0, 0, "R8");
  endtask

  task automatic t_saturate();
    cfg_target = 14'd0; cfg_reject = 14'd16383; cfg_gain = 3'd0;
    do_reset();
    for (int i = 0; i < 24; i++) step(1000, 1, 0, "R2");
    idle(0);
    step(500, 0, 0, "R7");
    check(pix_out_data == 14'd0, "R7", pix_out_data, 0);
    cfg_target = 14'd2000;
    do_reset();
    for (int i = 0; i < 24; i++) step(100, 1, 0, "R2");
    idle(0);
    step(16000, 0, 0, "R7");
    check(pix_out_data == 14'd16383, "R7", pix_out_data, 16383);
  endtask

  task automatic t_backpressure();
    logic [13:0] held;
    cfg_target = 14'd64; cfg_reject = 14'd4000; cfg_gain = 3'd0;
    do_reset();
    step(1111, 0, 0, "R10");
    held = pix_out_data;
    @(negedge clk);
    pix_out_ready = 1'b0; pix_in_valid = 1'b1; pix_in_data = 14'd2222;
    #1;
    check(pix_in_ready == 1'b0, "R10", pix_in_ready, 0);
    @(posedge clk); #1;
    check(pix_out_valid == 1'b1, "R10", pix_out_valid, 1);
    check(pix_out_data == held, "R10", pix_out_data, held);
    @(negedge clk);
    pix_out_ready = 1'b1;
    @(posedge clk); #1;
    check(pix_out_data == 14'd2222, "R10", pix_out_data, 2222);
    check(pix_out_valid == 1'b1, "R10", pix_out_valid, 1);
    @(negedge clk);
    pix_in_valid = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    t_reset_state();
    t_passthrough();
    t_first_hot();
    t_converge();
    t_hot_line();
    t_blank();
    t_cfg_latch();
    t_saturate();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule